// File: doc/BRIEF.md
# Two-Wire Slave Address Front End

This block is the receiving edge of a two-wire serial slave. It brings the clock and data lines into the system clock domain and finds the frame boundaries on them. It then shifts in the first byte of each frame and decides whether the frame is meant for this device. The first byte has no direction bit. Its upper nibble is a fixed device-type code and its lower nibble must equal four strap pins that set the board address.

When the address matches, the block pulls the data line low for the acknowledge clock. It then passes every later byte of the frame to a command interface as a one-cycle strobe, and it acknowledges each of those bytes. The first byte forwarded in a frame is marked as the instruction byte. A stop condition that closes a selected frame raises a one-cycle frame-end pulse. The command logic can use that pulse to launch an internal nonvolatile write.

While that write runs, the command logic holds the busy input high. During that time the block refuses to acknowledge its own address, so a master can poll with repeated start-plus-address attempts until an acknowledge comes back. A frame that is refused or addressed elsewhere is ignored until the next start condition.

Top module: `twi_addr_frontend`

## Requirements
- R1: While reset is asserted, `sda_pull_o`, `cmd_valid_o` and `frame_end_o` are all low.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Data bits are taken on the rising SCL edge, most significant bit first.
- R3: The address byte is acknowledged when bits [7:4] equal `DEV_TYPE` (default 4'b0101) and bits [3:0] equal `strap_i`.
- R4: If either nibble of the address differs, no acknowledge is given. Every following byte up to the next start is then neither acknowledged nor forwarded.
- R5: If `busy_i` is high when the address byte completes, the address is not acknowledged and the rest of the frame is ignored. The same address is acknowledged once `busy_i` is low again.
- R6: Each byte received after an acknowledged address appears on `cmd_data_o` with `cmd_valid_o` high for exactly one clock. `cmd_first_o` is 1 for the first such byte of a frame and 0 for the later ones.
- R7: Every byte forwarded under R6 is acknowledged.
- R8: `sda_pull_o` rises only after the falling SCL edge that ends the eighth bit. It falls after the following falling SCL edge, and it never changes while SCL is high.
- R9: A stop that ends a selected frame gives one `frame_end_o` pulse of one clock. A stop that ends an ignored frame gives none.
- R10: A repeated start, meaning a start with no stop before it, begins a new address phase whatever state the previous frame was in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| strap_i | input | PIN_W | Board address straps compared with the low address nibble |
| busy_i | input | 1 | Internal nonvolatile write in progress |
| sda_pull_o | output | 1 | 1 pulls the data line low (acknowledge) |
| cmd_valid_o | output | 1 | One-cycle strobe for a forwarded byte |
| cmd_first_o | output | 1 | Forwarded byte is the first after the address |
| cmd_data_o | output | TYPE_W+PIN_W | Forwarded byte |
| frame_end_o | output | 1 | One-cycle pulse on stop closing a selected frame |

## Verification
The bench builds the block with its defaults: a four-bit type code of 0101, four strap pins and a two-stage synchronizer. With those values the byte is eight bits wide, so frames built by hand can exercise every address decision. The cases covered are a type-nibble mismatch, a pin-nibble mismatch, two different strap settings and the busy refusal, all within short frames. Each serial bit lasts twenty system clocks, which leaves room for the three-cycle path from line to decision. A bus model running on every clock watches for an acknowledge pulled outside its expected window and for any forwarded byte that was not sent.

// File: rtl/twi_addr_frontend.sv
module twi_addr_frontend #(
  parameter int TYPE_W = 4,
  parameter int PIN_W = 4,
  parameter logic [TYPE_W-1:0] DEV_TYPE = TYPE_W'(4'b0101),
  parameter int SYNC_STAGES = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      scl_i,
  input  logic                      sda_i,
  input  logic [PIN_W-1:0]          strap_i,
  input  logic                      busy_i,
  output logic                      sda_pull_o,
  output logic                      cmd_valid_o,
  output logic                      cmd_first_o,
  output logic [TYPE_W+PIN_W-1:0]   cmd_data_o,
  output logic                      frame_end_o
);
  localparam int BYTE_W = TYPE_W + PIN_W;
  localparam int CNT_W = $clog2(BYTE_W + 2);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] ACK_CNT = CNT_W'(BYTE_W + 1);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} state_t;

  logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  state_t state;
  logic [CNT_W-1:0] cnt;
  logic [BYTE_W-1:0] shreg;
  logic first;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
      scl_d  <= scl_sh[SYNC_STAGES-1];
      sda_d  <= sda_sh[SYNC_STAGES-1];
    end

  wire scl_s    = scl_sh[SYNC_STAGES-1];
  wire sda_s    = sda_sh[SYNC_STAGES-1];
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;
  wire start    = scl_s & scl_d & sda_d & ~sda_s;
  wire stop     = scl_s & scl_d & ~sda_d & sda_s;
  wire addr_hit = (shreg[BYTE_W-1 -: TYPE_W] == DEV_TYPE) && (shreg[PIN_W-1:0] == strap_i);
  wire receiving = (state == S_ADDR) || (state == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      shreg       <= '0;
      first       <= 1'b0;
      sda_pull_o  <= 1'b0;
      cmd_valid_o <= 1'b0;
      cmd_first_o <= 1'b0;
      cmd_data_o  <= '0;
      frame_end_o <= 1'b0;
    end else begin
      cmd_valid_o <= 1'b0;
      frame_end_o <= 1'b0;
      if (stop) begin
        frame_end_o <= (state == S_DATA);
        state       <= S_IDLE;
        cnt         <= '0;
        sda_pull_o  <= 1'b0;
      end else if (start) begin
        state      <= S_ADDR;
        cnt        <= '0;
        first      <= 1'b1;
        sda_pull_o <= 1'b0;
      end else if (receiving) begin
        if (scl_rise && cnt < LAST_BIT) begin
          shreg <= {shreg[BYTE_W-2:0], sda_s};
          cnt   <= cnt + 1'b1;
        end else if (scl_fall && cnt == LAST_BIT) begin
          cnt <= ACK_CNT;
          if (state == S_ADDR) begin
            if (addr_hit && !busy_i) begin
              sda_pull_o <= 1'b1;
              state      <= S_DATA;
            end else begin
              state <= S_SKIP;
            end
          end else begin
            sda_pull_o  <= 1'b1;
            cmd_valid_o <= 1'b1;
            cmd_data_o  <= shreg;
            cmd_first_o <= first;
            first       <= 1'b0;
          end
        end else if (scl_fall && cnt == ACK_CNT) begin
          sda_pull_o <= 1'b0;
          cnt        <= '0;
        end
      end
    end

  a_r6_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid_o |=> !cmd_valid_o);
  a_r9_end_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end_o |=> !frame_end_o);
  a_r4_skip_no_forward: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_SKIP) |=> !cmd_valid_o && !sda_pull_o);
  a_r5_busy_refuses: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ADDR && cnt == LAST_BIT && scl_fall && busy_i) |=> !sda_pull_o);
  a_r8_release_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o && scl_fall && !stop && !start) |=> !sda_pull_o);
  a_r8_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && scl_d && !start && !stop) |=> $stable(sda_pull_o));
endmodule

// File: tb/twi_addr_frontend_test.sv
module twi_addr_frontend_test;
  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
  logic [3:0] strap = 4'b1010;
  logic pull, cv, cf, fe;
  logic [7:0] cd;
  wire sda_line = sda_m & ~pull;

  always #4 clk = ~clk;

  twi_addr_frontend uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .strap_i(strap),
    .busy_i(busy), .sda_pull_o(pull), .cmd_valid_o(cv), .cmd_first_o(cf),
    .cmd_data_o(cd), .frame_end_o(fe));

  int checks = 0, errors = 0, obs_ends = 0, exp_ends = 0;
  logic [8:0] q[$];
  logic [8:0] e;
  bit allow = 0, exp_first = 0;

  always @(negedge clk) if (rst_n) begin
    checks++;
    if (pull && !allow) begin
      errors++;
      $display("FAIL R8 pull outside ack window: actual %0b expected 0", pull);
    end
    if (cv) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R4/R6 unexpected byte: actual %h expected none", cd);
      end else begin
        e = q.pop_front();
        if ({cf, cd} != e) begin
          errors++;
          $display("FAIL R6 forwarded byte: actual %h expected %h", {cf, cd}, e);
        end
      end
    end
    if (fe) obs_ends++;
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    sda_m = 1; tick(5); scl = 1; tick(10); sda_m = 0; tick(10); scl = 0; tick(5);
    exp_first = 1;
  endtask

  task automatic do_stop(bit sel);
    sda_m = 0; tick(5); scl = 1; tick(10); sda_m = 1; tick(10);
    if (sel) exp_ends++;
    tick(6);
    checks++;
    if (obs_ends != exp_ends) begin
      errors++;
      $display("FAIL R9 frame ends: actual %0d expected %0d", obs_ends, exp_ends);
    end
  endtask

  task automatic send_byte(logic [7:0] b, bit exp_ack, bit fwd, string req);
    if (fwd) begin q.push_back({exp_first, b}); exp_first = 0; end
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(5); scl = 1; tick(10); scl = 0;
      if (i == 0) allow = exp_ack;
      tick(5);
    end
    sda_m = 1; tick(5); scl = 1; tick(5);
    checks++;
    if ((sda_line == 1'b0) != exp_ack) begin
      errors++;
      $display("FAIL %s ack on byte %h: actual %0b expected %0b", req, b, !sda_line, exp_ack);
    end
    tick(5); scl = 0; tick(5); allow = 0;
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6 byte not forwarded: actual none expected %h", q[0]);
      q.delete();
    end
  endtask

  initial begin
    tick(3);
    checks++;
    if (pull || cv || fe) begin
      errors++;
      $display("FAIL R1 reset outputs: actual %0b%0b%0b expected 000", pull, cv, fe);
    end
    rst_n = 1; tick(10);

    // R2 R3 R6 R7 R9: selected frame with instruction and data byte
    do_start();
    send_byte({4'b0101, strap}, 1, 0, "R3");
    send_byte(8'hA1, 1, 1, "R7");
    send_byte(8'h2C, 1, 1, "R7");
    do_stop(1);

    // R4: wrong type nibble, later byte ignored, no frame end
    do_start();
    send_byte({4'b0111, strap}, 0, 0, "R4");
    send_byte(8'hC3, 0, 0, "R4");
    do_stop(0);

    // R4: wrong pin nibble
    do_start();
    send_byte({4'b0101, 4'b1011}, 0, 0, "R4");
    send_byte(8'h5A, 0, 0, "R4");
    do_stop(0);

    // R3: other strap value
    strap = 4'b0011;
    do_start();
    send_byte(8'h53, 1, 0, "R3");
    send_byte(8'hFF, 1, 1, "R7");
    do_stop(1);

    // R5: busy refuses address, then polling succeeds
    busy = 1;
    do_start();
    send_byte(8'h53, 0, 0, "R5");
    send_byte(8'h90, 0, 0, "R5");
    do_stop(0);
    busy = 0;
    do_start();
    send_byte(8'h53, 1, 0, "R5");
    send_byte(8'h00, 1, 1, "R7");
    do_stop(1);

    // R10: repeated start after an ignored frame and after a selected frame
    do_start();
    send_byte(8'h13, 0, 0, "R10");
    do_start();
    send_byte(8'h53, 1, 0, "R10");
    send_byte(8'h81, 1, 1, "R10");
    do_start();
    send_byte(8'h53, 1, 0, "R10");
    send_byte(8'h7E, 1, 1, "R10");
    send_byte(8'h01, 1, 1, "R6");
    do_stop(1);

    tick(10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule